// File: doc/BRIEF.md
# DMA Operation Control Register with Cycle-Steal Pacing

This block holds the single 16-bit control and status word that governs a multi-channel DMA engine as a whole. Software uses it to turn every channel on or off with one master enable bit, to choose a channel priority scheme, and to pick a pacing mode for cycle-steal transfers. Two sticky status flags report an address error and a non-maskable interrupt. While either flag is set, the DMA engine is not allowed to move data.

The flags follow a read-then-clear protocol. A flag clears only on a write of zero to its bit, and only if software saw that flag as one in an earlier read of the register. That read arms an internal marker, and the next write to the register consumes the marker. Writing a one to a flag bit never changes the flag.

The pacing unit takes the arbiter's transfer request and issues a one-cycle transfer permit. In the intermittent modes it spaces the permits 16 or 64 bus clocks apart, but only when every channel is in cycle-steal bus mode. In every other case, permits follow the request cycle for cycle.

The block has two reset inputs:
- Power-on reset clears the whole register.
- Manual (warm) reset keeps the register contents. It clears only the pacing state and the read markers.

Top module: `dmac_opctl`

## Requirements
- R1: While the power-on reset is low, and just after it is released, the register reads 0x0000 and `dma_enable`, `chan_priority` and `xfer_permit` are all zero.
- R2: Bits 15:14, 11:10 and 7:3 always read as zero, whatever value is written to them.
- R3: A write stores bits 13:12 (pacing mode), bits 9:8 (priority) and bit 0 (master enable). Each reads back as written, including the mode value 01. The stored priority and enable values drive `chan_priority` and `dma_enable`.
- R4: A one-cycle pulse on `addr_err_evt` sets bit 2, and a pulse on `nmi_evt` sets bit 1. A write of one to either bit leaves that flag unchanged.
- R5: A flag clears on a write of zero to its bit only if a register read returned that flag as one after the previous write. A zero write with no such read leaves the flag set.
- R6: If a set pulse arrives in the same cycle as a write that would clear the flag, the flag stays set.
- R7: A manual reset keeps the mode, priority, enable and flag bits. It discards any armed read marker, so a later zero write without a fresh read does not clear a flag.
- R8: The bus is in normal mode when the mode field is 00, or in any unpaced case. In normal mode, `xfer_permit` equals `xfer_req` in every cycle in which the enable is one and both flags are zero.
- R9: With mode 10 and all channels in cycle-steal mode, a continuous request gets a permit in the first cycle and then exactly every 16 cycles.
- R10: With mode 11 and all channels in cycle-steal mode, a continuous request gets a permit in the first cycle and then exactly every 64 cycles.
- R11: If any bit of `ch_cyc_steal` is zero, or the mode field is 01, the bus runs in normal mode (no pacing).
- R12: `xfer_permit` is zero whenever the enable bit is zero or either flag is set.
- R13: A change of the effective pacing mode restarts the interval. The first request after the change is permitted at once, and the next permit comes a full new interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| warm_rst_n | input | 1 | Manual reset, active low, asynchronous; clears pacing state and read markers only |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, valid with `reg_sel` |
| reg_rd | input | 1 | Read strobe, valid with `reg_sel`; arms markers for flags read as one |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register value |
| ch_cyc_steal | input | NUM_CH | Per-channel bus mode, 1 = cycle steal |
| addr_err_evt | input | 1 | One-cycle address error event |
| nmi_evt | input | 1 | One-cycle NMI event |
| xfer_req | input | 1 | Transfer request from the arbiter |
| dma_enable | output | 1 | Master enable bit |
| chan_priority | output | 2 | Priority mode field |
| xfer_permit | output | 1 | One-cycle permit to perform a transfer |

## Verification
The bench probes the flag protocol at its edges, where a faulty design can go wrong in several ways:
- **Unarmed zero write.** A design that clears on any zero write drops the flag on this write.
- **Stale marker.** A design that never consumes its marker clears a flag on a second zero write without a fresh read.
- **Set and clear together.** A design that gives the clear priority loses an event that arrives in the cycle of the clearing write.
- **Manual reset.** A design that resets fields on a manual reset loses the enable and the mode.

On the pacing side, the bench checks the exact cycle of every permit under a continuous request in both interval modes, and how the unit restarts after a mid-interval mode change:
- An off-by-one counter shows up as spacing of 15 or 17 cycles instead of 16.
- A unit that ignores the per-channel bus modes, or the prohibited mode value, throttles transfers that should run every cycle.
- A unit that does not restart on a mode change delays the first permit after the change.

// File: rtl/dmac_opctl_pkg.sv
package dmac_opctl_pkg;

  localparam int REG_W     = 16;
  localparam int EN_BIT    = 0;
  localparam int FLAG_LSB  = 1;
  localparam int NUM_FLAGS = 2;
  localparam int PRI_LSB   = 8;
  localparam int CMS_LSB   = 12;
  localparam logic [REG_W-1:0] RSVD_MASK = 16'hCCF8;

  typedef enum logic [1:0] {
    PACE_FREE = 2'd0,
    PACE_FAST = 2'd1,
    PACE_SLOW = 2'd2
  } pace_e;

  // Effective pacing: intermittent only with all channels in cycle steal.
  function automatic pace_e pace_decode(logic [1:0] cms, logic all_cs);
    pace_e m;
    m = PACE_FREE;
    if (all_cs) begin
      case (cms)
        2'b10:   m = PACE_FAST;
        2'b11:   m = PACE_SLOW;
        default: m = PACE_FREE;
      endcase
    end
    return m;
  endfunction

  // Counter reload after a permit: interval minus one, zero when unpaced.
  function automatic int unsigned pace_reload(pace_e m, int unsigned fast_ivl,
                                              int unsigned slow_ivl);
    int unsigned r;
    case (m)
      PACE_FAST: r = fast_ivl - 1;
      PACE_SLOW: r = slow_ivl - 1;
      default:   r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dmac_opctl_flag.sv
module dmac_opctl_flag (
  input  logic clk,
  input  logic por_n,
  input  logic mark_rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o,
  output logic clr_o
);

  logic flag_q;
  logic armed_q;

  assign clr_o   = wr_i && !wbit_i && armed_q && flag_q && !set_i;
  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  // Flag lives in the power-on domain only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_o)  flag_q <= 1'b0;
  end

  // Read-as-one marker: armed by a read seeing one, consumed by any write.
  always_ff @(posedge clk or negedge mark_rst_n) begin
    if (!mark_rst_n)            armed_q <= 1'b0;
    else if (wr_i)              armed_q <= 1'b0;
    else if (rd_i && flag_q)    armed_q <= 1'b1;
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!por_n)
    set_i |=> flag_q);

  p_no_clr_unarmed_r5: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && !armed_q) |=> flag_q);

  p_one_write_keeps_r4: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && wr_i && wbit_i) |=> flag_q);

endmodule

// File: rtl/dmac_opctl_pacer.sv
module dmac_opctl_pacer
  import dmac_opctl_pkg::*;
#(
  parameter int unsigned FAST_IVL = 16,
  parameter int unsigned SLOW_IVL = 64,
  localparam int CNT_W = $clog2(SLOW_IVL)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pace_e mode_i,
  input  logic  fire_i,
  output logic  ready_o,
  output logic  mode_chg_o
);

  pace_e            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload     = CNT_W'(pace_reload(mode_i, FAST_IVL, SLOW_IVL));
  assign mode_chg_o = (mode_i != mode_q);
  assign ready_o    = (mode_i == PACE_FREE) || (cnt_q == '0) || mode_chg_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PACE_FREE;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_i;
      if (fire_i)             cnt_q <= reload;
      else if (mode_chg_o)    cnt_q <= '0;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_gap_after_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && mode_i != PACE_FREE) |=> (!ready_o || mode_chg_o));

  p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !fire_i && !mode_chg_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg_o && !fire_i) |=> (cnt_q == '0));

endmodule

// File: rtl/dmac_opctl.sv
module dmac_opctl
  import dmac_opctl_pkg::*;
#(
  parameter int          NUM_CH   = 8,
  parameter int unsigned FAST_IVL = 16,
  parameter int unsigned SLOW_IVL = 64
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] ch_cyc_steal,
  input  logic              addr_err_evt,
  input  logic              nmi_evt,
  input  logic              xfer_req,
  output logic              dma_enable,
  output logic [1:0]        chan_priority,
  output logic              xfer_permit
);

  logic                 wr_hit;
  logic                 rd_hit;
  logic                 mark_rst_n;
  logic [1:0]           cms_q;
  logic [1:0]           pri_q;
  logic                 en_q;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_armed;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_set;
  logic                 all_cs;
  pace_e                pace_mode;
  logic                 pace_ready;
  logic                 pace_chg;
  logic                 flags_any;

  assign wr_hit     = reg_sel && reg_wr;
  assign rd_hit     = reg_sel && reg_rd;
  assign mark_rst_n = por_n && warm_rst_n;
  assign flag_set   = {addr_err_evt, nmi_evt};
  assign all_cs     = &ch_cyc_steal;
  assign pace_mode  = pace_decode(cms_q, all_cs);
  assign flags_any  = |flag_q;

  // Control fields: power-on domain only, untouched by manual reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cms_q <= '0;
      pri_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_hit) begin
      cms_q <= reg_wdata[CMS_LSB +: 2];
      pri_q <= reg_wdata[PRI_LSB +: 2];
      en_q  <= reg_wdata[EN_BIT];
    end
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    dmac_opctl_flag u_flag (
      .clk        (clk),
      .por_n      (por_n),
      .mark_rst_n (mark_rst_n),
      .set_i      (flag_set[g]),
      .rd_i       (rd_hit),
      .wr_i       (wr_hit),
      .wbit_i     (reg_wdata[FLAG_LSB + g]),
      .flag_o     (flag_q[g]),
      .armed_o    (flag_armed[g]),
      .clr_o      (flag_clr[g])
    );
  end

  dmac_opctl_pacer #(
    .FAST_IVL (FAST_IVL),
    .SLOW_IVL (SLOW_IVL)
  ) u_pacer (
    .clk        (clk),
    .rst_n      (mark_rst_n),
    .mode_i     (pace_mode),
    .fire_i     (xfer_permit),
    .ready_o    (pace_ready),
    .mode_chg_o (pace_chg)
  );

  always_comb begin
    reg_rdata                          = '0;
    reg_rdata[EN_BIT]                  = en_q;
    reg_rdata[FLAG_LSB +: NUM_FLAGS]   = flag_q;
    reg_rdata[PRI_LSB +: 2]            = pri_q;
    reg_rdata[CMS_LSB +: 2]            = cms_q;
  end

  assign dma_enable    = en_q;
  assign chan_priority = pri_q;
  assign xfer_permit   = xfer_req && en_q && !flags_any && pace_ready;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata & RSVD_MASK) == '0);

  p_field_store_r3: assert property (@(posedge clk) disable iff (!por_n)
    wr_hit |=> (cms_q == $past(reg_wdata[CMS_LSB +: 2]) &&
                pri_q == $past(reg_wdata[PRI_LSB +: 2]) &&
                en_q  == $past(reg_wdata[EN_BIT])));

  p_gate_r12: assert property (@(posedge clk) disable iff (!por_n)
    xfer_permit |-> (dma_enable && !flags_any));

  p_warm_keep_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && !wr_hit) |=> ($stable(cms_q) && $stable(pri_q) && $stable(en_q)));

  p_unpaced_follow_r11: assert property (@(posedge clk) disable iff (!por_n)
    (!all_cs && xfer_req && en_q && !flags_any) |-> xfer_permit);

endmodule

// File: tb/test_dmac_opctl.sv
`timescale 1ns/1ps
module test_dmac_opctl;

  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NCH-1:0] ch_cyc_steal = '1;
  logic        addr_err_evt = 1'b0;
  logic        nmi_evt = 1'b0;
  logic        xfer_req = 1'b0;
  logic        dma_enable;
  logic [1:0]  chan_priority;
  logic        xfer_permit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmac_opctl #(.NUM_CH(NCH), .FAST_IVL(16), .SLOW_IVL(64)) i_dmac_opctl (
    .clk, .por_n, .warm_rst_n, .reg_sel, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .ch_cyc_steal, .addr_err_evt, .nmi_evt, .xfer_req, .dma_enable,
    .chan_priority, .xfer_permit
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(output logic [15:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic pulse_ae();
    @(negedge clk); addr_err_evt = 1'b1;
    @(negedge clk); addr_err_evt = 1'b0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_evt = 1'b1;
    @(negedge clk); nmi_evt = 1'b0;
  endtask

  task automatic clear_flags();
    logic [15:0] v;
    rd(v);
    wr(16'h0000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rdata in reset", reg_rdata, 0);
    chk("R1 outputs in reset", {dma_enable, chan_priority, xfer_permit}, 0);
    por_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 rdata after reset", reg_rdata, 0);
  endtask

  task automatic t_fields();
    logic [15:0] v;
    wr(16'hFFFF);
    rd(v);
    chk("R2 reserved zero after all-ones write", v, 16'h3301);
    wr(16'h1201);
    rd(v);
    chk("R3 readback incl. mode 01", v, 16'h1201);
    chk("R3 enable/priority outputs", {dma_enable, chan_priority}, 3'b110);
    wr(16'h0000);
  endtask

  task automatic t_flags();
    logic [15:0] v;
    pulse_ae();
    wr(16'h0004);
    rd(v);
    chk("R4 ae set, one-write ignored", v, 16'h0004);
    wr(16'h0004);
    wr(16'h0000);
    rd(v);
    chk("R5 marker consumed by prior write", v, 16'h0004);
    wr(16'h0000);
    rd(v);
    chk("R5 clear after read-as-one", v, 16'h0000);
    pulse_nmi();
    wr(16'h0000);
    rd(v);
    chk("R5 nmi unarmed zero write keeps flag", v, 16'h0002);
    wr(16'h0000);
    rd(v);
    chk("R4 R5 nmi cleared after read", v, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    pulse_ae();
    rd(v);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0000; addr_err_evt = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; addr_err_evt = 1'b0;
    rd(v);
    chk("R6 set beats clear", v, 16'h0004);
    wr(16'h0000);
  endtask

  task automatic t_warm();
    logic [15:0] v;
    wr(16'h2201);
    pulse_nmi();
    rd(v);
    @(negedge clk); warm_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    warm_rst_n = 1'b1;
    rd(v);
    chk("R7 contents kept over manual reset", v, 16'h2203);
    warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    wr(16'h2201);
    rd(v);
    chk("R7 marker discarded by manual reset", v, 16'h2203);
    wr(16'h0000);
    rd(v);
    chk("R7 cleanup clear", v, 16'h0000);
  endtask

  task automatic t_normal();
    int bad;
    wr(16'h0001);
    @(negedge clk); xfer_req = 1'b1;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      #1 if (xfer_permit !== 1'b1) bad++;
      @(negedge clk);
    end
    chk("R8 permit every cycle in normal mode", bad, 0);
    xfer_req = 1'b0; #1;
    chk("R8 no permit without request", xfer_permit, 0);
    xfer_req = 1'b1;
    wr(16'h0000);
    #1 chk("R12 enable low blocks permit", xfer_permit, 0);
    wr(16'h0001);
    pulse_nmi();
    #1 chk("R12 flag set blocks permit", xfer_permit, 0);
    xfer_req = 1'b0;
    clear_flags();
  endtask

  task automatic t_pace(input logic [15:0] mode_word, input int ivl, input string tag);
    int bad, seen;
    xfer_req = 1'b0;
    ch_cyc_steal = '1;
    wr(mode_word);
    @(negedge clk); xfer_req = 1'b1;
    bad = 0; seen = 0;
    for (int i = 0; i < 2 * ivl + 4; i++) begin
      #1;
      if (xfer_permit) seen++;
      if (xfer_permit !== ((i % ivl) == 0)) bad++;
      @(negedge clk);
    end
    xfer_req = 1'b0;
    chk({tag, " permit cycle pattern"}, bad, 0);
    chk({tag, " permit count"}, seen, 3);
    wr(16'h0000);
  endtask

  task automatic t_unpaced();
    int bad;
    wr(16'h2001);
    ch_cyc_steal = 8'hFE;
    @(negedge clk); xfer_req = 1'b1;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      #1 if (xfer_permit !== 1'b1) bad++;
      @(negedge clk);
    end
    chk("R11 one channel not cycle steal -> unpaced", bad, 0);
    xfer_req = 1'b0;
    ch_cyc_steal = '1;
    wr(16'h1001);
    @(negedge clk); xfer_req = 1'b1;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      #1 if (xfer_permit !== 1'b1) bad++;
      @(negedge clk);
    end
    chk("R11 mode 01 -> unpaced", bad, 0);
    xfer_req = 1'b0;
    wr(16'h0000);
  endtask

  task automatic t_mode_change();
    int bad;
    ch_cyc_steal = '1;
    wr(16'h3001);
    @(negedge clk); xfer_req = 1'b1;
    #1 chk("R13 first permit in slow mode", xfer_permit, 1);
    repeat (5) @(negedge clk);
    wr(16'h2001);
    #1 chk("R13 permit right after mode change", xfer_permit, 1);
    @(negedge clk);
    bad = 0;
    for (int i = 1; i <= 16; i++) begin
      #1 if (xfer_permit !== (i == 16)) bad++;
      @(negedge clk);
    end
    chk("R13 next permit one fast interval later", bad, 0);
    xfer_req = 1'b0;
    wr(16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fields();
    t_flags();
    t_set_wins();
    t_warm();
    t_normal();
    t_pace(16'h2001, 16, "R9");
    t_pace(16'h3001, 64, "R10");
    t_unpaced();
    t_mode_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule